// File: doc/BRIEF.md
# Strobe-Reloaded Watchdog Timer

This block is a software watchdog built around a down counter that advances on a slow 32 Hz tick, one count per 31.25 ms. Software sets a reload value in a separate load register and then restarts the countdown by writing a strobe bit. The load register is guarded by an active-low write-enable bit. While that bit is 1, writes to the load register are dropped.

If software does not strobe in time, the counter expires. The watchdog flag is then set and, when enabled, a fixed-width pulse is driven that can serve as a processor reset. The counter reloads itself and keeps running. A load value of zero turns the whole function off. The counter only moves while the oscillator reports that it is running.

Every pin is a plain control or status signal. No data stream passes through the block, so there is no valid/ready handshake and no back-pressure. A register write takes effect on the clock edge that samples it.

Top module: `strobe_watchdog`

## Requirements
- R1: After reset the write-protect bit is 1, the load register and counter are 0, and `wd_flag` and `wd_pulse` are 0.
- R2: A load write (`ld_wr`) changes the load register only when the registered write-protect bit is 0. While that bit is 1, the write is ignored.
- R3: A control write (`ctl_wr`) copies `ctl_lock` into the write-protect bit. The new value governs load writes from the next cycle on.
- R4: A control write with `ctl_strobe`=1 copies the load register into the counter. With no further strobe, expiry then occurs on exactly the N-th counted tick, where N is the load value.
- R5: A tick is counted only in a cycle where `tick` and `osc_run` are both 1. Ticks that arrive while `osc_run`=0 do not advance the counter.
- R6: On expiry the counter reloads from the load register. Without a strobe, expiry therefore repeats every N counted ticks.
- R7: Expiry sets `wd_flag` on the next edge. A `flag_rd` clears the flag, except when it coincides with an expiry; in that case the flag stays set.
- R8: If `irq_en` is 1 at expiry, `wd_pulse` is high for exactly PULSE_LEN cycles starting the cycle after. If `irq_en` is 0, no pulse is produced, although the flag is still set.
- R9: While the load register holds 0, ticks cause no expiry, no flag and no pulse.
- R10: A strobe in the same cycle as a counted tick has priority. The counter reloads and no expiry occurs in that cycle, even if the counter was at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle pulse at 32 Hz |
| osc_run | input | 1 | Oscillator running indication |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_lock | input | 1 | Write-protect bit value (1 = load register protected) |
| ctl_strobe | input | 1 | Reload request bit, acts only in the write cycle |
| ld_wr | input | 1 | Load register write strobe |
| ld_data | input | LOAD_W | Load value to write |
| flag_rd | input | 1 | Flags register read strobe, clears the flag |
| irq_en | input | 1 | Enables the expiry pulse |
| wd_flag | output | 1 | Watchdog expiry flag |
| wd_pulse | output | 1 | Interrupt / reset pulse |

## Verification
The bench sweeps every nonzero load value and counts ticks to the first expiry. An off-by-one counter would expire one tick early or late. It also measures the pulse width after every expiry, where a wrong pulse counter would give a short or stretched reset.

Write-protect is tested by writing while locked. A design that ignored the bit would expire at the new value instead of the old one.

Several coincidences are targeted. A strobe on the same cycle as the final tick must reload and not expire. A read on the same cycle as an expiry must not lose the flag. Ticks with the oscillator stopped must not count; a design that ignored `osc_run` would expire early. A zero load value, and a disabled pulse, must stay silent.

// File: rtl/swd_pkg.sv
package swd_pkg;
  localparam int unsigned SWD_LOAD_W_DEF = 6;
  localparam int unsigned SWD_PULSE_DEF  = 4;

  typedef struct packed {
    logic lock;
    logic strobe;
  } swd_ctl_t;
endpackage

// File: rtl/swd_regs.sv
module swd_regs #(
  parameter int unsigned LOAD_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_wr,
  input  swd_pkg::swd_ctl_t ctl_in,
  input  logic              ld_wr,
  input  logic [LOAD_W-1:0] ld_data,
  output logic [LOAD_W-1:0] load_q,
  output logic              reload
);
  logic lock_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_q <= 1'b1;
      load_q <= '0;
    end else begin
      if (ctl_wr) lock_q <= ctl_in.lock;
      if (ld_wr && !lock_q) load_q <= ld_data;
    end
  end

  // self-clearing: only present in the write cycle
  assign reload = ctl_wr && ctl_in.strobe;

  // R2
  locked_load_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q |=> $stable(load_q));
  // R3
  lock_follows_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_wr |=> (lock_q == $past(ctl_in.lock)));
endmodule

// File: rtl/swd_counter.sv
module swd_counter #(
  parameter int unsigned LOAD_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              osc_run,
  input  logic              reload,
  input  logic [LOAD_W-1:0] load_val,
  output logic              expire
);
  logic [LOAD_W-1:0] cnt_q;
  logic              step;
  logic              last;

  assign step   = tick && osc_run && (load_val != '0) && !reload;
  assign last   = (cnt_q <= LOAD_W'(1));
  assign expire = step && last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (reload) begin
      cnt_q <= load_val;
    end else if (step) begin
      if (last) cnt_q <= load_val;
      else      cnt_q <= cnt_q - LOAD_W'(1);
    end
  end

  // R5
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!(tick && osc_run) && !reload) |=> $stable(cnt_q));
  // R4
  strobe_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reload |=> (cnt_q == $past(load_val)));
  // R6
  expire_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> (cnt_q == $past(load_val)));
  // R10
  strobe_blocks_expire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reload |-> !expire);
endmodule

// File: rtl/swd_pulse.sv
module swd_pulse #(
  parameter int unsigned PULSE_LEN = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  input  logic enable,
  output logic pulse
);
  localparam int unsigned PW = $clog2(PULSE_LEN + 1);
  logic [PW-1:0] left_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      left_q <= '0;
    end else if (fire && enable) begin
      left_q <= PW'(PULSE_LEN);
    end else if (left_q != '0) begin
      left_q <= left_q - PW'(1);
    end
  end

  assign pulse = (left_q != '0);

  // R8
  pulse_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && enable) |=> pulse);
  // R8
  pulse_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pulse) |-> $past(fire && enable));
endmodule

// File: rtl/strobe_watchdog.sv
module strobe_watchdog #(
  parameter int unsigned LOAD_W    = swd_pkg::SWD_LOAD_W_DEF,
  parameter int unsigned PULSE_LEN = swd_pkg::SWD_PULSE_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              osc_run,
  input  logic              ctl_wr,
  input  logic              ctl_lock,
  input  logic              ctl_strobe,
  input  logic              ld_wr,
  input  logic [LOAD_W-1:0] ld_data,
  input  logic              flag_rd,
  input  logic              irq_en,
  output logic              wd_flag,
  output logic              wd_pulse
);
  swd_pkg::swd_ctl_t ctl_in;
  logic [LOAD_W-1:0] load_q;
  logic              reload;
  logic              expire;
  logic              flag_q;

  assign ctl_in.lock   = ctl_lock;
  assign ctl_in.strobe = ctl_strobe;

  swd_regs #(.LOAD_W(LOAD_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_in(ctl_in),
    .ld_wr(ld_wr), .ld_data(ld_data), .load_q(load_q), .reload(reload)
  );

  swd_counter #(.LOAD_W(LOAD_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .osc_run(osc_run),
    .reload(reload), .load_val(load_q), .expire(expire)
  );

  swd_pulse #(.PULSE_LEN(PULSE_LEN)) u_pulse (
    .clk(clk), .rst_n(rst_n), .fire(expire), .enable(irq_en), .pulse(wd_pulse)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag_q <= 1'b0;
    else if (expire)  flag_q <= 1'b1;
    else if (flag_rd) flag_q <= 1'b0;
  end

  assign wd_flag = flag_q;

  // R7
  flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> wd_flag);
  // R7
  flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_rd && !expire) |=> !wd_flag);
  // R9
  zero_load_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load_q == '0) |-> !expire);
endmodule

// File: tb/strobe_watchdog_tb.sv
module strobe_watchdog_tb;
  localparam int W  = 6;
  localparam int PL = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 0, osc_run = 1, ctl_wr = 0, ctl_lock = 0, ctl_strobe = 0;
  logic ld_wr = 0, flag_rd = 0, irq_en = 1;
  logic [W-1:0] ld_data = '0;
  logic wd_flag, wd_pulse;
  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #5 clk = ~clk;

  strobe_watchdog #(.LOAD_W(W), .PULSE_LEN(PL)) u_dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .osc_run(osc_run),
    .ctl_wr(ctl_wr), .ctl_lock(ctl_lock), .ctl_strobe(ctl_strobe),
    .ld_wr(ld_wr), .ld_data(ld_data), .flag_rd(flag_rd), .irq_en(irq_en),
    .wd_flag(wd_flag), .wd_pulse(wd_pulse)
  );

  task automatic check(string tag, int got, int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic tick1();
    tick = 1; @(negedge clk); tick = 0;
  endtask
  task automatic wr_load(int v);
    ld_wr = 1; ld_data = W'(v); @(negedge clk); ld_wr = 0;
  endtask
  task automatic wr_ctl(bit l, bit s);
    ctl_wr = 1; ctl_lock = l; ctl_strobe = s; @(negedge clk);
    ctl_wr = 0; ctl_strobe = 0;
  endtask
  task automatic rd_flags();
    flag_rd = 1; @(negedge clk); flag_rd = 0;
  endtask
  task automatic arm(int v);
    wr_ctl(0, 0); wr_load(v); wr_ctl(1, 1); rd_flags();
  endtask
  task automatic ticks_to_flag(int maxt, output int k);
    k = 0;
    for (int i = 1; i <= maxt; i++) begin
      tick1();
      if (wd_flag) begin k = i; break; end
    end
  endtask
  task automatic pulse_width(output int w);
    w = 0;
    while (wd_pulse && w < 20) begin w++; @(negedge clk); end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: got hang expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int k, w;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check("R1 flag", wd_flag, 0);
    check("R1 pulse", wd_pulse, 0);
    ticks_to_flag(80, k);
    check("R1 load zero after reset", k, 0);

    // R4 R8 sweep of every load value
    for (int n = 1; n < (1 << W); n++) begin
      arm(n);
      ticks_to_flag(n + 2, k);
      check("R4 ticks to expiry", k, n);
      pulse_width(w);
      check("R8 pulse width", w, PL);
    end

    // R6 periodic reload
    arm(3);
    ticks_to_flag(10, k); check("R6 first", k, 3);
    rd_flags(); check("R7 read clears", wd_flag, 0);
    ticks_to_flag(10, k); check("R6 repeat", k, 3);

    // R2 write while locked is ignored
    arm(7);
    wr_load(20); wr_ctl(1, 1);
    ticks_to_flag(30, k); check("R2 locked write ignored", k, 7);
    // R3 unlock lets write through
    wr_ctl(0, 0); wr_load(9); wr_ctl(1, 1); rd_flags();
    ticks_to_flag(30, k); check("R3 unlocked write", k, 9);

    // R5 oscillator stopped
    arm(5);
    tick1(); tick1();
    osc_run = 0;
    repeat (10) tick1();
    check("R5 no expiry when stopped", wd_flag, 0);
    osc_run = 1;
    ticks_to_flag(10, k); check("R5 remaining ticks", k, 3);

    // R10 strobe coincides with final tick
    arm(4);
    repeat (3) tick1();
    ctl_wr = 1; ctl_lock = 1; ctl_strobe = 1; tick = 1;
    @(negedge clk);
    ctl_wr = 0; ctl_strobe = 0; tick = 0;
    check("R10 no expiry on strobe", wd_flag, 0);
    check("R10 no pulse", wd_pulse, 0);
    ticks_to_flag(10, k); check("R10 full reload", k, 4);

    // R7 set wins over read
    arm(2);
    tick1();
    flag_rd = 1; tick = 1; @(negedge clk); flag_rd = 0; tick = 0;
    check("R7 set wins", wd_flag, 1);
    rd_flags(); check("R7 cleared", wd_flag, 0);

    // R8 pulse disabled
    repeat (6) @(negedge clk);
    irq_en = 0;
    arm(1);
    tick1();
    check("R8 flag without enable", wd_flag, 1);
    check("R8 no pulse", wd_pulse, 0);
    repeat (3) @(negedge clk);
    check("R8 still no pulse", wd_pulse, 0);
    irq_en = 1;

    // R9 zero load disables
    arm(0);
    ticks_to_flag(150, k);
    check("R9 zero load never expires", k, 0);
    check("R9 no pulse", wd_pulse, 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule